// File: doc/BRIEF.md
# Serial Port Automatic Bit-Rate Calibrator

This block finds the bit rate of an asynchronous 8N1 serial link from a calibration byte sent by a host. After a start strobe it waits until the receive line has been idle high for a while. It then times the unbroken low run made by a 0x00 character. That run is the start bit plus eight zero data bits, which is nine bit times. The block divides the cycle count by nine, rounding to nearest, and the result is the number of clock cycles per bit.

The divisor is loaded into the block's own serial transmitter and receiver. The transmitter sends one 0x00 character back at the measured rate. The receiver then waits for the host to reply with 0x55. A correct reply makes the block report lock. A wrong byte, a low stop bit, or no reply within a fixed number of bit times raises the error flag, and the block goes back to hunting for a new calibration byte. Host rates of 9600 and 19200 bit/s are meant to be used with system clocks of 8 to 18 MHz and 16 to 18 MHz respectively. The default counter width covers the longest span, about 16900 cycles at 18 MHz and 9600 bit/s.

Top module: `autobaud_lock`

## Requirements
- R1: After reset tx_o is high, locked_o and error_o are low and divisor_o is zero.
- R2: A pulse on start_i makes the block wait for at least IDLE_MIN consecutive cycles of rx_i high before it times a low span. A low span that is already in progress when start_i pulses is not measured: divisor_o does not change and tx_o stays high.
- R3: For an accepted low span of L cycles, divisor_o becomes (L+4)/9 in integer division, which is L/9 rounded to nearest. divisor_o changes only when a span is accepted.
- R4: A low span shorter than GLITCH_MIN cycles is discarded. divisor_o does not change, nothing is transmitted, and the block keeps hunting.
- R5: After an accepted span, tx_o sends exactly one 0x00 frame at the new rate: tx_o is low for 9 × divisor_o cycles and then returns high. tx_o is high whenever no frame is being sent.
- R6: After the acknowledge frame, a received 8N1 byte of 0x55 (LSB first) with a high stop bit sets locked_o and leaves error_o low.
- R7: A received reply byte other than 0x55 sets error_o, leaves locked_o low, and returns the block to hunting.
- R8: A reply whose stop bit is sampled low counts as a failed confirmation, with the same result as R7.
- R9: If no reply starts within WAIT_BITS bit times after the acknowledge frame ends, error_o is set and the block returns to hunting. Before that limit error_o stays low.
- R10: A pulse on start_i clears error_o and locked_o and restarts the hunt.
- R11: While the block is locked, activity on rx_i is ignored: locked_o stays high, divisor_o keeps its value and tx_o stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high, asynchronous |
| start_i | input | 1 | One-cycle strobe that starts or restarts calibration |
| tx_o | output | 1 | Serial transmit line, idle high |
| divisor_o | output | CNT_W | Measured clock cycles per bit |
| locked_o | output | 1 | Calibration confirmed |
| error_o | output | 1 | Last confirmation failed or timed out |

## Verification
The assertions assume that start_i is a single-cycle strobe. They also assume that the host holds each bit of its reply for the divisor the block measured, and starts the reply only after the acknowledge frame. The assertion that the divisor changes only on an accepted span assumes that rx_i makes whole low spans and does not toggle fast enough to confuse the synchroniser.

The stimulus drives rx_i only on the falling clock edge, in whole-cycle runs, with a quiet high gap of more than IDLE_MIN cycles before each calibration span. Every reply is sent at exactly the expected divisor and only after the acknowledge frame has been seen to end on tx_o.

// File: rtl/abr_pkg.sv
package abr_pkg;
  localparam int unsigned SPAN_BITS    = 9;
  localparam int unsigned SPAN_ROUND   = SPAN_BITS / 2;
  localparam int unsigned DATA_BITS    = 8;
  localparam logic [7:0]  ACK_BYTE     = 8'h00;
  localparam logic [7:0]  CONFIRM_BYTE = 8'h55;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HUNT, ST_ARMED, ST_MEAS, ST_ACK, ST_WAIT, ST_LOCK
  } cal_state_e;

  typedef enum logic [1:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP
  } rx_state_e;
endpackage

// File: rtl/abr_sync.sv
module abr_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rx_s_o = sync_q;
  assign fall_o = prev_q & ~sync_q;
  assign rise_o = ~prev_q & sync_q;
endmodule

// File: rtl/abr_tx.sv
module abr_tx #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] div_i,
  input  logic             load_i,
  input  logic [7:0]       data_i,
  output logic             tx_o,
  output logic             busy_o,
  output logic             done_o
);
  import abr_pkg::*;

  logic [8:0]       sh_q, sh_d;
  logic [3:0]       left_q, left_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, tx_q, tx_d, done_q, done_d;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    tx_d   = tx_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (load_i) begin
        sh_d   = {1'b1, data_i};
        left_d = 4'(DATA_BITS + 1);
        cnt_d  = div_i - 1'b1;
        busy_d = 1'b1;
        tx_d   = 1'b0;
      end
    end else if (cnt_q == '0) begin
      cnt_d = div_i - 1'b1;
      if (left_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        tx_d   = 1'b1;
      end else begin
        tx_d   = sh_q[0];
        sh_d   = {1'b1, sh_q[8:1]};
        left_d = left_q - 1'b1;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      tx_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      tx_q   <= tx_d;
      done_q <= done_d;
    end
  end

  assign tx_o   = tx_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_tx_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> tx_q);
  assert_tx_done_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && tx_q));
endmodule

// File: rtl/abr_rx.sv
module abr_rx #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rx_s_i,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] div_i,
  output logic             done_o,
  output logic [7:0]       data_o,
  output logic             frame_ok_o
);
  import abr_pkg::*;

  rx_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             done_q, done_d, fok_q, fok_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    fok_d  = fok_q;
    if (!en_i) begin
      st_d = RX_IDLE;
    end else begin
      case (st_q)
        RX_IDLE: if (fall_i) begin
          cnt_d = (div_i >> 1) - 1'b1;
          st_d  = RX_START;
        end
        RX_START: if (cnt_q == '0) begin
          if (!rx_s_i) begin
            cnt_d = div_i - 1'b1;
            bit_d = '0;
            st_d  = RX_DATA;
          end else begin
            st_d = RX_IDLE;
          end
        end else cnt_d = cnt_q - 1'b1;
        RX_DATA: if (cnt_q == '0) begin
          sh_d  = {rx_s_i, sh_q[7:1]};
          cnt_d = div_i - 1'b1;
          if (bit_q == 3'(DATA_BITS - 1)) st_d = RX_STOP;
          else bit_d = bit_q + 1'b1;
        end else cnt_d = cnt_q - 1'b1;
        RX_STOP: if (cnt_q == '0) begin
          done_d = 1'b1;
          fok_d  = rx_s_i;
          st_d   = RX_IDLE;
        end else cnt_d = cnt_q - 1'b1;
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
      fok_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      done_q <= done_d;
      fok_q  <= fok_d;
    end
  end

  assign done_o     = done_q;
  assign data_o     = sh_q;
  assign frame_ok_o = fok_q;

  assert_rx_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/autobaud_lock.sv
module autobaud_lock #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned GLITCH_MIN = 72,
  parameter int unsigned IDLE_MIN   = 32,
  parameter int unsigned WAIT_BITS  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             start_i,
  output logic             tx_o,
  output logic [CNT_W-1:0] divisor_o,
  output logic             locked_o,
  output logic             error_o
);
  import abr_pkg::*;

  localparam int unsigned WD_W    = $clog2(WAIT_BITS + 1);
  localparam int unsigned CNT_SAT = (1 << CNT_W) - 1 - SPAN_ROUND;

  cal_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, div_q, div_d, span_q;
  logic [CNT_W-1:0] wd_cyc_q, wd_cyc_d;
  logic [WD_W-1:0]  wd_bits_q, wd_bits_d;
  logic             err_q, err_d, tx_load;
  logic             rx_s, rx_fall, rx_rise;
  logic             tx_busy, tx_done, rx_en, rx_done, rx_fok;
  logic [7:0]       rx_data;

  abr_sync u_sync (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
    .rx_s_o(rx_s), .fall_o(rx_fall), .rise_o(rx_rise)
  );

  abr_tx #(.CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div_i(div_d), .load_i(tx_load),
    .data_i(ACK_BYTE), .tx_o(tx_o), .busy_o(tx_busy), .done_o(tx_done)
  );

  abr_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en_i(rx_en), .rx_s_i(rx_s), .fall_i(rx_fall),
    .div_i(div_q), .done_o(rx_done), .data_o(rx_data), .frame_ok_o(rx_fok)
  );

  assign rx_en  = (state_q == ST_WAIT);
  assign span_q = (cnt_q + CNT_W'(SPAN_ROUND)) / CNT_W'(SPAN_BITS);

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    div_d     = div_q;
    err_d     = err_q;
    wd_cyc_d  = wd_cyc_q;
    wd_bits_d = wd_bits_q;
    tx_load   = 1'b0;
    if (start_i) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
      err_d   = 1'b0;
    end else begin
      case (state_q)
        ST_HUNT: begin
          if (!rx_s) cnt_d = '0;
          else if (cnt_q >= CNT_W'(IDLE_MIN - 1)) begin
            cnt_d   = '0;
            state_d = ST_ARMED;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_ARMED: if (rx_fall) begin
          cnt_d   = CNT_W'(1);
          state_d = ST_MEAS;
        end
        ST_MEAS: begin
          if (rx_rise) begin
            cnt_d = '0;
            if (cnt_q < CNT_W'(GLITCH_MIN)) state_d = ST_HUNT;
            else begin
              div_d   = span_q;
              tx_load = 1'b1;
              state_d = ST_ACK;
            end
          end else if (cnt_q < CNT_W'(CNT_SAT)) cnt_d = cnt_q + 1'b1;
        end
        ST_ACK: if (tx_done) begin
          wd_cyc_d  = '0;
          wd_bits_d = '0;
          state_d   = ST_WAIT;
        end
        ST_WAIT: begin
          if (rx_done) begin
            if (rx_fok && rx_data == CONFIRM_BYTE) begin
              state_d = ST_LOCK;
              err_d   = 1'b0;
            end else begin
              state_d = ST_HUNT;
              err_d   = 1'b1;
            end
          end else if (wd_bits_q == WD_W'(WAIT_BITS)) begin
            state_d = ST_HUNT;
            err_d   = 1'b1;
          end else if (wd_cyc_q == div_q - 1'b1) begin
            wd_cyc_d  = '0;
            wd_bits_d = wd_bits_q + 1'b1;
          end else wd_cyc_d = wd_cyc_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      div_q     <= '0;
      err_q     <= 1'b0;
      wd_cyc_q  <= '0;
      wd_bits_q <= '0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      div_q     <= div_d;
      err_q     <= err_d;
      wd_cyc_q  <= wd_cyc_d;
      wd_bits_q <= wd_bits_d;
    end
  end

  assign divisor_o = div_q;
  assign locked_o  = (state_q == ST_LOCK);
  assign error_o   = err_q;

  assert_lock_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked_o && error_o));
  assert_div_on_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> (state_q == ST_ACK && tx_busy));
  assert_wd_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_bits_q <= WD_W'(WAIT_BITS));
  assert_lock_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && !start_i) |=> (locked_o && $stable(div_q)));
  assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!error_o && !locked_o));
endmodule

// File: tb/test_autobaud_lock.sv
`timescale 1ns/1ps
module test_autobaud_lock;
  localparam int CNT_W = 16, GLITCH_MIN = 72, IDLE_MIN = 32, WAIT_BITS = 64;
  localparam int NV = 5;
  localparam int         V_LEN [NV] = '{144, 149, 148, 200, 117};
  localparam logic [7:0] V_REP [NV] = '{8'h55, 8'h55, 8'h54, 8'h55, 8'h55};
  localparam bit         V_STOP[NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam bit         V_LOCK[NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, start = 1'b0;
  logic tx, locked, err;
  logic [CNT_W-1:0] div;
  int n_chk = 0, n_fail = 0, tx_low_total = 0;

  always #4 clk = ~clk;

  autobaud_lock #(.CNT_W(CNT_W), .GLITCH_MIN(GLITCH_MIN), .IDLE_MIN(IDLE_MIN),
                  .WAIT_BITS(WAIT_BITS)) i_autobaud_lock (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .start_i(start),
    .tx_o(tx), .divisor_o(div), .locked_o(locked), .error_o(err));

  always @(negedge clk) if (!tx) tx_low_total <= tx_low_total + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic send_byte(input int bt, input logic [7:0] b, input logic stop);
    rx = 1'b0; idle(bt);
    for (int i = 0; i < 8; i++) begin rx = b[i]; idle(bt); end
    rx = stop; idle(bt);
    rx = 1'b1;
  endtask

  // drives a low span, returns measured ack low length on tx
  task automatic span_and_ack(input int len, output int ack_low);
    int guard;
    rx = 1'b0; idle(len); rx = 1'b1;
    guard = 0;
    while (tx && guard < 2000) begin @(negedge clk); guard++; end
    ack_low = 0;
    while (!tx && ack_low < 20000) begin @(negedge clk); ack_low++; end
  endtask

  initial begin
    int ack_low, exp_div, snap;
    idle(3);
    check(tx === 1'b1 && locked === 1'b0 && err === 1'b0 && div === '0, "R1", int'(div), 0);
    rst_n = 1'b1;
    idle(2);
    check(tx === 1'b1 && locked === 1'b0 && err === 1'b0, "R1", int'({tx, locked, err}), 4);

    for (int v = 0; v < NV; v++) begin
      exp_div = (V_LEN[v] + 4) / 9;
      pulse_start();
      idle(IDLE_MIN + 8);
      span_and_ack(V_LEN[v], ack_low);
      check(int'(div) == exp_div, "R3", int'(div), exp_div);
      check(ack_low == 9 * exp_div, "R5", ack_low, 9 * exp_div);
      idle(2 * exp_div);
      send_byte(exp_div, V_REP[v], V_STOP[v]);
      idle(exp_div);
      if (V_LOCK[v])
        check(locked === 1'b1 && err === 1'b0, "R6", int'({locked, err}), 2);
      else if (!V_STOP[v])
        check(locked === 1'b0 && err === 1'b1, "R8", int'({locked, err}), 1);
      else
        check(locked === 1'b0 && err === 1'b1, "R7", int'({locked, err}), 1);
    end

    // R10: start clears error (last vector locked; make an error first)
    pulse_start();
    idle(IDLE_MIN + 8);
    span_and_ack(144, ack_low);
    idle(2 * 16);
    send_byte(16, 8'hAA, 1'b1);
    idle(16);
    check(err === 1'b1, "R7", int'(err), 1);
    pulse_start();
    check(err === 1'b0 && locked === 1'b0, "R10", int'({locked, err}), 0);

    // R9: watchdog on missing reply
    idle(IDLE_MIN + 8);
    span_and_ack(144, ack_low);
    idle(16 + 32 * 16);
    check(err === 1'b0, "R9", int'(err), 0);
    idle(32 * 16 + 40);
    check(err === 1'b1 && locked === 1'b0, "R9", int'({locked, err}), 1);

    // R2: span already in progress at start is not timed
    rx = 1'b0;
    pulse_start();
    idle(144);
    rx = 1'b1;
    snap = tx_low_total;
    idle(300);
    check(tx_low_total == snap, "R2", tx_low_total - snap, 0);
    check(int'(div) == 16, "R2", int'(div), 16);

    // R4: short glitch ignored, then valid span accepted
    rx = 1'b0; idle(40); rx = 1'b1;
    snap = tx_low_total;
    idle(300);
    check(tx_low_total == snap, "R4", tx_low_total - snap, 0);
    check(int'(div) == 16, "R4", int'(div), 16);
    span_and_ack(117, ack_low);
    check(int'(div) == 13, "R4", int'(div), 13);
    idle(26);
    send_byte(13, 8'h55, 1'b1);
    idle(13);
    check(locked === 1'b1, "R6", int'(locked), 1);

    // R11: rx ignored while locked
    snap = tx_low_total;
    rx = 1'b0; idle(200); rx = 1'b1;
    idle(400);
    check(locked === 1'b1 && int'(div) == 13, "R11", int'(div), 13);
    check(tx_low_total == snap, "R11", tx_low_total - snap, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
    $finish;
  end
endmodule